// File: doc/BRIEF.md
# Saturating Halfword Multiply-Accumulator

This block multiplies two signed 16-bit operands and adds the product into a two-word accumulator. The low word always takes the new sum. The high word behaves differently in the two modes. In wide mode it holds a 10-bit signed extension of the low word, so the running total is 42 bits. In saturating mode the low word is limited to the 32-bit signed range, and bit 0 of the high word works as a sticky overflow flag.

Each operand is fetched from memory outside the block; the fetched halfwords arrive here as inputs. The block also takes the two source pointers used for those fetches and returns each one advanced by two bytes, so that a sequencer can stream through two halfword arrays. All results appear in registers one clock after a valid strobe. A synchronous clear empties the accumulator.

Top module: `halfword_mac`

## Requirements
- R1: While rst_n is low, and after it is released with no strobe given, acc_hi, acc_lo, ptr_a_out and ptr_b_out are all zero.
- R2: When clr is high at a rising edge, acc_hi and acc_lo are both zero after that edge, even if valid is also high.
- R3: When neither valid nor clr is high at an edge, acc_hi and acc_lo keep their values.
- R4: When valid is high at an edge, ptr_a_out and ptr_b_out take ptr_a_in + 2 and ptr_b_in + 2 after that edge, wrapping modulo 2^32. This happens whatever clr and sat_mode are. Without valid, the pointer outputs hold.
- R5: The product is the signed 16x16 product of op_a and op_b, sign-extended to 32 bits. In wide mode (sat_mode = 0), a strobe sets acc_lo to acc_lo + product modulo 2^32.
- R6: In saturating mode (sat_mode = 1), overflow occurs when the product and acc_lo have the same sign bit and the sum's sign bit differs from it. An overflow sets acc_hi bit 0, and no later accumulation clears that bit; only clr or reset does.
- R7: On a saturating-mode overflow, acc_lo becomes 0x80000000 if the product is negative and 0x7FFFFFFF otherwise.
- R8: In saturating mode, acc_hi bits 31:1 are never changed, and without overflow acc_lo becomes the plain 32-bit sum.
- R9: In wide mode, acc_hi first takes the sum of three terms: its old value, the product's sign extension (all ones for a negative product) and the carry out of the unsigned low-word sum. Only bits 9:0 of that result are kept, and they are sign-extended from bit 9 to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous accumulator clear |
| valid | input | 1 | Operands and pointers valid this cycle |
| sat_mode | input | 1 | 1 = saturating 32-bit mode, 0 = wide 42-bit mode |
| op_a | input | 16 | First signed halfword operand |
| op_b | input | 16 | Second signed halfword operand |
| ptr_a_in | input | 32 | Address the first operand came from |
| ptr_b_in | input | 32 | Address the second operand came from |
| acc_hi | output | 32 | Accumulator high word |
| acc_lo | output | 32 | Accumulator low word |
| ptr_a_out | output | 32 | First pointer after post-increment |
| ptr_b_out | output | 32 | Second pointer after post-increment |

## Verification
The bench builds the block with its default parameters: 16-bit operands, 32-bit pointers, a step of two and a 10-bit high-word extension. With a 10-bit extension, the high word overflows past bit 9 after about two thousand maximum-magnitude products. That count is small enough to run fully, so the bench directly checks the sign-extension wrap from +511 to -512. The two clamp values are checked with the extreme operand -32768, and the pointer step is checked across the 2^32 wrap.

// File: rtl/hwmac_pkg.sv
package hwmac_pkg;

  localparam int HM_ACC_W = 32;

  typedef enum logic {
    ACC_WIDE = 1'b0,
    ACC_SAT  = 1'b1
  } acc_mode_e;

  typedef struct packed {
    logic [HM_ACC_W-1:0] hi;
    logic [HM_ACC_W-1:0] lo;
  } acc_pair_t;

endpackage

// File: rtl/hm_product.sv
module hm_product
  import hwmac_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  output logic [HM_ACC_W-1:0] prod
);

  localparam int PROD_W = 2 * OP_W;

  function automatic logic [HM_ACC_W-1:0] mul_ext(input logic [OP_W-1:0] a,
                                                  input logic [OP_W-1:0] b);
    logic signed [PROD_W-1:0]   full;
    logic signed [HM_ACC_W-1:0] wide;
    full = $signed(a) * $signed(b);
    wide = HM_ACC_W'(full);
    return wide;
  endfunction

  assign prod = mul_ext(op_a, op_b);

endmodule

// File: rtl/hm_sat_path.sv
module hm_sat_path
  import hwmac_pkg::*;
(
  input  logic [HM_ACC_W-1:0] prod,
  input  acc_pair_t           acc_q,
  output acc_pair_t           acc_d,
  output logic                ovf
);

  localparam int MSB = HM_ACC_W - 1;

  function automatic logic sat_overflow(input logic [HM_ACC_W-1:0] p,
                                        input logic [HM_ACC_W-1:0] l);
    logic [HM_ACC_W-1:0] s;
    s = p + l;
    return (p[MSB] == l[MSB]) && (s[MSB] != p[MSB]);
  endfunction

  function automatic logic [HM_ACC_W-1:0] clamp_value(input logic neg);
    logic [HM_ACC_W-1:0] v;
    v      = {HM_ACC_W{~neg}};
    v[MSB] = neg;
    return v;
  endfunction

  assign ovf = sat_overflow(prod, acc_q.lo);

  always_comb begin
    acc_d.hi = acc_q.hi;
    acc_d.lo = prod + acc_q.lo;
    if (ovf) begin
      acc_d.hi[0] = 1'b1;
      acc_d.lo    = clamp_value(prod[MSB]);
    end
  end

endmodule

// File: rtl/hm_ext_path.sv
module hm_ext_path
  import hwmac_pkg::*;
#(
  parameter int EXT_W = 10
) (
  input  logic [HM_ACC_W-1:0] prod,
  input  acc_pair_t           acc_q,
  output acc_pair_t           acc_d
);

  localparam int MSB = HM_ACC_W - 1;

  function automatic logic [HM_ACC_W:0] low_sum(input logic [HM_ACC_W-1:0] p,
                                                input logic [HM_ACC_W-1:0] l);
    return {1'b0, p} + {1'b0, l};
  endfunction

  function automatic logic [HM_ACC_W-1:0] hi_update(input logic [HM_ACC_W-1:0] h,
                                                    input logic p_neg,
                                                    input logic carry);
    logic [HM_ACC_W-1:0]     t;
    logic signed [EXT_W-1:0] keep;
    logic signed [HM_ACC_W-1:0] ext;
    t    = h + {HM_ACC_W{p_neg}} + HM_ACC_W'(carry);
    keep = $signed(t[EXT_W-1:0]);
    ext  = HM_ACC_W'(keep);
    return ext;
  endfunction

  logic [HM_ACC_W:0] sum_c;

  assign sum_c    = low_sum(prod, acc_q.lo);
  assign acc_d.lo = sum_c[HM_ACC_W-1:0];
  assign acc_d.hi = hi_update(acc_q.hi, prod[MSB], sum_c[HM_ACC_W]);

endmodule

// File: rtl/hm_ptr_step.sv
module hm_ptr_step #(
  parameter int PTR_W    = 32,
  parameter int PTR_STEP = 2,
  parameter int N_PTR    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid,
  input  logic [N_PTR-1:0][PTR_W-1:0] ptr_d,
  output logic [N_PTR-1:0][PTR_W-1:0] ptr_q
);

  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(PTR_STEP);

  for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q[i] <= '0;
      else if (valid) ptr_q[i] <= ptr_d[i] + STEP_V;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> ptr_q[i] == $past(ptr_d[i]) + STEP_V); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(ptr_q[i])); // R4
  end

endmodule

// File: rtl/halfword_mac.sv
module halfword_mac
  import hwmac_pkg::*;
#(
  parameter int OP_W     = 16,
  parameter int PTR_W    = 32,
  parameter int PTR_STEP = 2,
  parameter int EXT_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                valid,
  input  logic                sat_mode,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  input  logic [PTR_W-1:0]    ptr_a_in,
  input  logic [PTR_W-1:0]    ptr_b_in,
  output logic [HM_ACC_W-1:0] acc_hi,
  output logic [HM_ACC_W-1:0] acc_lo,
  output logic [PTR_W-1:0]    ptr_a_out,
  output logic [PTR_W-1:0]    ptr_b_out
);

  localparam int N_PTR = 2;

  acc_mode_e           mode;
  logic [HM_ACC_W-1:0] prod;
  acc_pair_t           acc_q;
  acc_pair_t           sat_d;
  acc_pair_t           ext_d;
  acc_pair_t           acc_d;
  logic                sat_ovf;
  logic                do_acc;

  logic [N_PTR-1:0][PTR_W-1:0] ptr_d;
  logic [N_PTR-1:0][PTR_W-1:0] ptr_q;

  assign mode   = acc_mode_e'(sat_mode);
  assign do_acc = valid && !clr;

  hm_product #(.OP_W(OP_W)) u_prod (
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
  );

  hm_sat_path u_sat (
    .prod  (prod),
    .acc_q (acc_q),
    .acc_d (sat_d),
    .ovf   (sat_ovf)
  );

  hm_ext_path #(.EXT_W(EXT_W)) u_ext (
    .prod  (prod),
    .acc_q (acc_q),
    .acc_d (ext_d)
  );

  assign acc_d = (mode == ACC_SAT) ? sat_d : ext_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (valid)  acc_q <= acc_d;
  end

  assign acc_hi = acc_q.hi;
  assign acc_lo = acc_q.lo;

  assign ptr_d[0] = ptr_a_in;
  assign ptr_d[1] = ptr_b_in;

  hm_ptr_step #(.PTR_W(PTR_W), .PTR_STEP(PTR_STEP), .N_PTR(N_PTR)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (valid),
    .ptr_d (ptr_d),
    .ptr_q (ptr_q)
  );

  assign ptr_a_out = ptr_q[0];
  assign ptr_b_out = ptr_q[1];

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_hi == '0 && acc_lo == '0); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !valid |=> $stable(acc_hi) && $stable(acc_lo)); // R3
  AST_LOW_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    do_acc && !(mode == ACC_SAT && sat_ovf)
      |=> acc_lo == $past(acc_lo) + $past(prod)); // R5
  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    do_acc && mode == ACC_SAT && acc_hi[0] |=> acc_hi[0]); // R6
  AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    do_acc && mode == ACC_SAT && sat_ovf
      |=> acc_lo == 32'h7FFF_FFFF || acc_lo == 32'h8000_0000); // R7
  AST_SAT_HI_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    do_acc && mode == ACC_SAT |=> acc_hi[HM_ACC_W-1:1] == $past(acc_hi[HM_ACC_W-1:1])); // R8
  AST_WIDE_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
    do_acc && mode == ACC_WIDE
      |=> acc_hi[HM_ACC_W-1:EXT_W-1] == '0 || acc_hi[HM_ACC_W-1:EXT_W-1] == '1); // R9

endmodule

// File: tb/sim_halfword_mac.sv
module sim_halfword_mac;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        valid = 1'b0;
  logic        sat_mode = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [31:0] ptr_a_in = '0;
  logic [31:0] ptr_b_in = '0;
  logic [31:0] acc_hi, acc_lo, ptr_a_out, ptr_b_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] m_hi = '0, m_lo = '0, m_pa = '0, m_pb = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfword_mac u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .valid(valid), .sat_mode(sat_mode),
    .op_a(op_a), .op_b(op_b), .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out)
  );

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check32(tag, "acc_hi", acc_hi, m_hi);
    check32(tag, "acc_lo", acc_lo, m_lo);
    check32(tag, "ptr_a_out", ptr_a_out, m_pa);
    check32(tag, "ptr_b_out", ptr_b_out, m_pb);
  endtask

  // Reference: 42-bit signed view in wide mode, range test in saturating mode.
  task automatic model_step(input logic v, input logic c, input logic s,
                            input logic [15:0] a, input logic [15:0] b,
                            input logic [31:0] pa, input logic [31:0] pb);
    longint p, sum, acc42;
    if (v) begin
      m_pa = pa + 32'd2;
      m_pb = pb + 32'd2;
    end
    if (c) begin
      m_hi = '0;
      m_lo = '0;
    end else if (v) begin
      p = longint'($signed(a)) * longint'($signed(b));
      if (s) begin
        sum = longint'($signed(m_lo)) + p;
        if (sum > 64'sd2147483647 || sum < -64'sd2147483648) begin
          m_hi[0] = 1'b1;
          m_lo = (p < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end else begin
          m_lo = sum[31:0];
        end
      end else begin
        acc42 = (longint'($signed(m_hi[9:0])) <<< 32) + longint'(m_lo) + p;
        m_lo  = acc42[31:0];
        m_hi  = {{22{acc42[41]}}, acc42[41:32]};
      end
    end
  endtask

  // Called at a falling edge; drives, waits one rising edge, compares at the next falling edge.
  task automatic step(input logic v, input logic c, input logic s,
                      input logic [15:0] a, input logic [15:0] b,
                      input logic [31:0] pa, input logic [31:0] pb, input string tag);
    valid = v; clr = c; sat_mode = s; op_a = a; op_b = b; ptr_a_in = pa; ptr_b_in = pb;
    model_step(v, c, s, a, b, pa, pb);
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // R3: operands toggle without valid
    step(0, 0, 0, 16'h7FFF, 16'h7FFF, 32'h1234, 32'h5678, "R3 idle");
    step(0, 0, 1, 16'h8000, 16'h8000, 32'hFFFF, 32'h0, "R3 idle sat");

    // R5 / R4: wide mode basic products
    step(1, 0, 0, 16'd3, 16'd5, 32'h0000_1000, 32'h0000_2000, "R5 pos");
    step(1, 0, 0, 16'hFFFE, 16'd7, 32'h0000_1002, 32'h0000_2002, "R5 neg");
    step(1, 0, 0, 16'hFFFF, 16'd100, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R4 wrap");
    // R9: borrow into the high word and back
    step(1, 0, 0, 16'h8000, 16'h7FFF, 32'h10, 32'h20, "R9 borrow");
    step(1, 0, 0, 16'h8000, 16'h8000, 32'h10, 32'h20, "R9 carry");
    step(1, 0, 0, 16'h8000, 16'h8000, 32'h10, 32'h20, "R9 carry2");

    // R2: clear, also beats valid
    step(1, 1, 0, 16'h1234, 16'h4321, 32'h40, 32'h80, "R2 clr with valid");
    step(0, 1, 0, 16'h0, 16'h0, 32'h0, 32'h0, "R2 clr idle");

    // R9: grow the high word past bit 9 so it wraps to negative
    for (int i = 0; i < 2100; i++)
      step(1, 0, 0, 16'h8000, 16'h8000, 32'(i * 2), 32'(i * 4), "R9 wrap");
    step(0, 1, 0, 16'h0, 16'h0, 32'h0, 32'h0, "R2 clr");

    // R6 / R7: positive overflow
    step(1, 0, 1, 16'h8000, 16'h8000, 32'h100, 32'h200, "R8 no ovf");
    step(1, 0, 1, 16'h8000, 16'h8000, 32'h102, 32'h202, "R7 pos clamp");
    check32("R7 pos clamp", "value", acc_lo, 32'h7FFF_FFFF);
    check32("R6 flag set", "acc_hi", acc_hi, 32'h1);
    step(1, 0, 1, 16'hFFFF, 16'd1000, 32'h104, 32'h204, "R6 sticky");
    check32("R6 sticky", "acc_hi bit0", {31'b0, acc_hi[0]}, 32'h1);
    step(0, 1, 0, 16'h0, 16'h0, 32'h0, 32'h0, "R2 clr flag");

    // R7: negative overflow
    for (int i = 0; i < 3; i++)
      step(1, 0, 1, 16'h8000, 16'h7FFF, 32'h300, 32'h400, "R7 neg clamp");
    check32("R7 neg clamp", "value", acc_lo, 32'h8000_0000);
    step(0, 1, 0, 16'h0, 16'h0, 32'h0, 32'h0, "R2 clr");

    // R8: high word with bit 1 set keeps upper bits under saturating overflow
    for (int i = 0; i < 8; i++)
      step(1, 0, 0, 16'h8000, 16'h8000, 32'h500, 32'h600, "R9 build hi");
    for (int i = 0; i < 2; i++)
      step(1, 0, 1, 16'h8000, 16'h8000, 32'h500, 32'h600, "R8 upper hi");
    check32("R8 upper hi", "acc_hi", acc_hi, 32'h3);

    // mixed random traffic
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, ($urandom % 16) == 0, $urandom % 2,
           16'($urandom), 16'($urandom), $urandom, $urandom, "R5 R6 R9 random");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule